// File: doc/BRIEF.md
# NAND Cache-Program Device Engine

This block is a synthesizable behavioural model of the device side of a NAND flash that supports buffered page programming. It watches an 8-bit multiplexed bus and latches a cycle on each rising edge of the write strobe. The command-latch and address-latch qualifiers sort each cycle into a command, an address byte or a data byte. A load sequence fills a small cache register. A cache-program or page-program command then passes the cache contents to a data register, and from there the page is programmed into the array. A parameterised counter stands in for the array programming time. While a page is programmed, its bytes appear on a simple array write port.

The two registers let the host reload the cache while the array is still busy with the previous page. The ready/busy output tracks only the cache register. A status byte, returned after the status command, reports cache readiness and array readiness separately, together with pass/fail for the last two pages programmed. A fail-inject input marks the page being programmed as failed.

Top module: `nand_cache_prog`

## Requirements
- R1: Command 80h, accepted only while `rb` is high, presets every cache byte to FFh. Exactly five address cycles follow. The first gives the start column in its low log2(PAGE_BYTES) bits, the second is ignored, and the third to fifth give row bits 7:0, 15:8 and 23:16. Data cycles then fill the cache from the start column upward, and bytes beyond the last column are dropped.
- R2: A cycle is latched on the rising edge of `we_n`. It is a command when `cle`=1 and `ale`=0, an address when `ale`=1 and `cle`=0, and data when both are 0. A cycle with both qualifiers high is ignored.
- R3: Command 15h after a completed load drives `rb` low. If the array is idle, `rb` returns high exactly XFER_CYC clock edges after the edge that latched the command.
- R4: The data register is loaded when the transfer ends. Array programming starts on the same edge that `rb` returns high and lasts PROG_CYC cycles. From its first cycle, `arr_we` presents one byte per cycle in column order 0 to PAGE_BYTES-1, with `arr_row` holding the loaded row.
- R5: A 15h issued while the array is still programming holds the transfer back until the array finishes. `rb` then rises XFER_CYC edges after the array-done edge.
- R6: Command 10h keeps `rb` low until the array has finished programming that page. That is PROG_CYC edges after the point at which a 15h would have released `rb`.
- R7: The status byte has bit 6 = cache ready (equal to `rb`) and bit 5 = array ready (no transfer pending and array idle). Bit 0 is 1 if the most recently finished page failed, and bit 1 is 1 if the page before that failed. All other bits are 0. So, while a page is programming and the cache is ready, bit 0 reports the previous page.
- R8: Command 70h is accepted at any time. After it, `io_oe` is high and `io_out` carries the live status whenever `re_n` is low, whether `re_n` is held low or pulsed. Any other accepted command ends status output.
- R9: While `rb` is low, address cycles, data cycles and every command except 70h are ignored.
- R10: A high `fail_inject` in any cycle of a page's array programming marks that page as failed.
- R11: After reset, `rb` is high, `io_oe` and `arr_we` are low, and the status reads 60h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cle | input | 1 | Command-latch qualifier |
| ale | input | 1 | Address-latch qualifier |
| we_n | input | 1 | Write strobe; cycles latch on its rising edge |
| re_n | input | 1 | Read strobe; low drives the status byte |
| io_in | input | 8 | Bus byte from host |
| fail_inject | input | 1 | Marks the page currently programming as failed |
| io_out | output | 8 | Status byte when `io_oe` is high, else 0 |
| io_oe | output | 1 | Bus output enable |
| rb | output | 1 | Ready/busy, high when the cache register is free |
| arr_we | output | 1 | Array write strobe, one byte per cycle |
| arr_row | output | 24 | Row of the page being programmed |
| arr_col | output | log2(PAGE_BYTES) | Column of the byte on `arr_byte` |
| arr_byte | output | 8 | Byte written into the array |

## Verification
The bench builds the block with an 8-byte page, a 5-cycle transfer and a 96-cycle array program. With a program time much longer than a full page load, a second page can be loaded and committed while the first is still programming. This puts the held-back transfer, status reads during double busy, and ignored load attempts during busy within reach of short directed sequences. The short page makes partial loads, column wrap-off and FFh padding frequent under random start columns and lengths. Random gaps and random choices between 15h and 10h vary whether each commit lands on an idle or a busy array.

// File: rtl/nand_cp_pkg.sv
package nand_cp_pkg;

   localparam logic [7:0] OP_LOAD     = 8'h80;
   localparam logic [7:0] OP_CACHE_GO = 8'h15;
   localparam logic [7:0] OP_PAGE_GO  = 8'h10;
   localparam logic [7:0] OP_STATUS   = 8'h70;

   // address framing: column byte, spare column byte, then row bytes
   localparam int unsigned ADDR_CYCLES = 5;
   localparam int unsigned ROW_FIRST   = 2;
   localparam int unsigned ROW_BYTES   = ADDR_CYCLES - ROW_FIRST;
   localparam int unsigned ROW_W       = 8 * ROW_BYTES;

   // status byte bit positions
   localparam int unsigned SB_CACHE_RDY = 6;
   localparam int unsigned SB_ARRAY_RDY = 5;
   localparam int unsigned SB_FAIL_PREV = 1;
   localparam int unsigned SB_FAIL_LAST = 0;

   typedef enum logic [1:0] {LD_IDLE, LD_ADDR, LD_DATA} load_ph_e;
   typedef enum logic [1:0] {CQ_READY, CQ_WAIT, CQ_XFER, CQ_HOLD} cache_st_e;
   typedef enum logic {AR_IDLE, AR_PROG} arr_st_e;

   typedef struct packed {
      logic       cmd;
      logic       adr;
      logic       dat;
      logic [7:0] val;
   } bus_ev_t;

endpackage

// File: rtl/nand_cp_busif.sv
module nand_cp_busif import nand_cp_pkg::*; #(
   parameter bit REG_EVENTS = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cle,
   input  logic       ale,
   input  logic       we_n,
   input  logic [7:0] io_in,
   output bus_ev_t    ev_o
);

   logic    we_q;
   logic    we_rise;
   bus_ev_t ev_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_q <= 1'b1;
      else        we_q <= we_n;
   end

   assign we_rise    = we_n & ~we_q;
   assign ev_raw.cmd = we_rise &  cle & ~ale;
   assign ev_raw.adr = we_rise &  ale & ~cle;
   assign ev_raw.dat = we_rise & ~ale & ~cle;
   assign ev_raw.val = io_in;

   generate
      if (REG_EVENTS) begin : g_reg
         bus_ev_t ev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ev_q <= '0;
            else        ev_q <= ev_raw;
         end
         assign ev_o = ev_q;
      end else begin : g_comb
         assign ev_o = ev_raw;
      end
   endgenerate

endmodule

// File: rtl/nand_cp_cache.sv
module nand_cp_cache import nand_cp_pkg::*; #(
   parameter int unsigned PAGE_BYTES = 16,
   localparam int unsigned COL_W = $clog2(PAGE_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bus_ev_t          ev_i,
   input  logic             cache_rdy_i,
   output logic             go_cache_o,
   output logic             go_page_o,
   output logic [7:0]       page_o [PAGE_BYTES],
   output logic [ROW_W-1:0] row_o
);

   load_ph_e       ph;
   logic [2:0]     acnt;
   logic [COL_W:0] col;
   logic           cmd_ok, preset, adr_ok, wr_en;

   assign cmd_ok = ev_i.cmd & cache_rdy_i;
   assign preset = cmd_ok & (ev_i.val == OP_LOAD);
   assign adr_ok = ev_i.adr & cache_rdy_i & (ph == LD_ADDR);
   assign wr_en  = ev_i.dat & cache_rdy_i & (ph == LD_DATA) & ~col[COL_W];

   assign go_cache_o = cmd_ok & (ph == LD_DATA) & (ev_i.val == OP_CACHE_GO);
   assign go_page_o  = cmd_ok & (ph == LD_DATA) & (ev_i.val == OP_PAGE_GO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= LD_IDLE;
         acnt <= '0;
         col  <= '0;
      end else if (preset) begin
         ph   <= LD_ADDR;
         acnt <= '0;
         col  <= '0;
      end else if (cmd_ok) begin
         if (ev_i.val != OP_STATUS) ph <= LD_IDLE;
      end else if (adr_ok) begin
         if (acnt == 3'd0) col <= {1'b0, ev_i.val[COL_W-1:0]};
         if (acnt == 3'(ADDR_CYCLES - 1)) ph <= LD_DATA;
         acnt <= acnt + 3'd1;
      end else if (wr_en) begin
         col <= col + 1'b1;
      end
   end

   // row bytes, least significant first
   generate
      for (genvar b = 0; b < ROW_BYTES; b++) begin : g_row
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               row_o[8*b +: 8] <= '0;
            else if (adr_ok && acnt == 3'(ROW_FIRST + b))
               row_o[8*b +: 8] <= ev_i.val;
         end
      end
   endgenerate

   // cache register bytes, erased to FFh by each accepted load command
   generate
      for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               page_o[g] <= 8'hFF;
            else if (preset)
               page_o[g] <= 8'hFF;
            else if (wr_en && col[COL_W-1:0] == COL_W'(g))
               page_o[g] <= ev_i.val;
         end
      end
   endgenerate

   a_r1_col_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      col <= (COL_W+1)'(PAGE_BYTES));

   a_r9_col_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(col) |-> $past(cache_rdy_i));

endmodule

// File: rtl/nand_cp_engine.sv
module nand_cp_engine import nand_cp_pkg::*; #(
   parameter int unsigned PAGE_BYTES = 16,
   parameter int unsigned XFER_CYC   = 8,
   parameter int unsigned PROG_CYC   = 200,
   localparam int unsigned COL_W = $clog2(PAGE_BYTES),
   localparam int unsigned XW    = $clog2(XFER_CYC + 1),
   localparam int unsigned PW    = $clog2(PROG_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_cache_i,
   input  logic             go_page_i,
   input  logic [7:0]       page_i [PAGE_BYTES],
   input  logic [ROW_W-1:0] row_i,
   input  logic             fail_inject_i,
   output logic             cache_rdy_o,
   output logic             array_rdy_o,
   output logic             fail_last_o,
   output logic             fail_prev_o,
   output logic             arr_we_o,
   output logic [ROW_W-1:0] arr_row_o,
   output logic [COL_W-1:0] arr_col_o,
   output logic [7:0]       arr_byte_o
);

   cache_st_e      cst;
   arr_st_e        ast;
   logic [XW-1:0]  xcnt;
   logic [PW-1:0]  pcnt;
   logic [COL_W:0] idx;
   logic           hold_q, facc;
   logic [7:0]     dreg [PAGE_BYTES];
   logic           go_any, arr_done, arr_free, xfer_done;

   assign go_any    = go_cache_i | go_page_i;
   assign arr_done  = (ast == AR_PROG) && (pcnt == '0);
   assign arr_free  = (ast == AR_IDLE) || arr_done;
   assign xfer_done = (cst == CQ_XFER) && (xcnt == '0);

   // cache side: commit, wait for the array, transfer, optional hold
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cst    <= CQ_READY;
         xcnt   <= '0;
         hold_q <= 1'b0;
      end else begin
         unique case (cst)
            CQ_READY: if (go_any) begin
               hold_q <= go_page_i;
               if (arr_free) begin
                  cst  <= CQ_XFER;
                  xcnt <= XW'(XFER_CYC - 1);
               end else begin
                  cst <= CQ_WAIT;
               end
            end
            CQ_WAIT: if (arr_free) begin
               cst  <= CQ_XFER;
               xcnt <= XW'(XFER_CYC - 1);
            end
            CQ_XFER: begin
               if (xcnt == '0) cst  <= hold_q ? CQ_HOLD : CQ_READY;
               else            xcnt <= xcnt - 1'b1;
            end
            CQ_HOLD: if (arr_done) cst <= CQ_READY;
            default: cst <= CQ_READY;
         endcase
      end
   end

   // array side: timed program with byte stream and pass/fail history
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ast         <= AR_IDLE;
         pcnt        <= '0;
         idx         <= '0;
         facc        <= 1'b0;
         fail_last_o <= 1'b0;
         fail_prev_o <= 1'b0;
         arr_row_o   <= '0;
      end else begin
         unique case (ast)
            AR_IDLE: if (xfer_done) begin
               ast       <= AR_PROG;
               pcnt      <= PW'(PROG_CYC - 1);
               idx       <= '0;
               facc      <= 1'b0;
               arr_row_o <= row_i;
            end
            AR_PROG: begin
               facc <= facc | fail_inject_i;
               if (!idx[COL_W]) idx <= idx + 1'b1;
               if (pcnt == '0) begin
                  ast         <= AR_IDLE;
                  fail_last_o <= facc | fail_inject_i;
                  fail_prev_o <= fail_last_o;
               end else begin
                  pcnt <= pcnt - 1'b1;
               end
            end
            default: ast <= AR_IDLE;
         endcase
      end
   end

   generate
      for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_dreg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         dreg[g] <= '0;
            else if (xfer_done) dreg[g] <= page_i[g];
         end
      end
   endgenerate

   assign cache_rdy_o = (cst == CQ_READY);
   assign array_rdy_o = (ast == AR_IDLE) && (cst == CQ_READY);
   assign arr_we_o    = (ast == AR_PROG) && !idx[COL_W];
   assign arr_col_o   = idx[COL_W-1:0];
   assign arr_byte_o  = dreg[idx[COL_W-1:0]];

   a_r4_xfer_into_idle_array: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (ast == AR_IDLE));

   a_r3_busy_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cache_rdy_o) |-> $past(go_any));

   a_r6_hold_tracks_array: assert property (@(posedge clk) disable iff (!rst_n)
      (cst == CQ_HOLD) |-> (ast == AR_PROG));

endmodule

// File: rtl/nand_cache_prog.sv
module nand_cache_prog import nand_cp_pkg::*; #(
   parameter int unsigned PAGE_BYTES = 16,
   parameter int unsigned XFER_CYC   = 8,
   parameter int unsigned PROG_CYC   = 200,
   parameter bit          REG_EVENTS = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cle,
   input  logic                          ale,
   input  logic                          we_n,
   input  logic                          re_n,
   input  logic [7:0]                    io_in,
   input  logic                          fail_inject,
   output logic [7:0]                    io_out,
   output logic                          io_oe,
   output logic                          rb,
   output logic                          arr_we,
   output logic [ROW_W-1:0]              arr_row,
   output logic [$clog2(PAGE_BYTES)-1:0] arr_col,
   output logic [7:0]                    arr_byte
);

   generate
      if (PAGE_BYTES < 2 || PAGE_BYTES > 256 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two from 2 to 256");
      end
      if (XFER_CYC < 1) begin : g_bad_xfer
         $error("XFER_CYC must be at least 1");
      end
      if (PROG_CYC < PAGE_BYTES) begin : g_bad_prog
         $error("PROG_CYC must cover one byte per column");
      end
   endgenerate

   bus_ev_t          ev;
   logic             go_cache, go_page;
   logic [7:0]       cpage [PAGE_BYTES];
   logic [ROW_W-1:0] crow;
   logic             cache_rdy, array_rdy, fail_last, fail_prev;
   logic             stat_mode;
   logic [7:0]       status;

   nand_cp_busif #(.REG_EVENTS(REG_EVENTS)) u_busif (
      .clk  (clk),
      .rst_n(rst_n),
      .cle  (cle),
      .ale  (ale),
      .we_n (we_n),
      .io_in(io_in),
      .ev_o (ev)
   );

   nand_cp_cache #(.PAGE_BYTES(PAGE_BYTES)) u_cache (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_i       (ev),
      .cache_rdy_i(cache_rdy),
      .go_cache_o (go_cache),
      .go_page_o  (go_page),
      .page_o     (cpage),
      .row_o      (crow)
   );

   nand_cp_engine #(
      .PAGE_BYTES(PAGE_BYTES),
      .XFER_CYC  (XFER_CYC),
      .PROG_CYC  (PROG_CYC)
   ) u_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .go_cache_i   (go_cache),
      .go_page_i    (go_page),
      .page_i       (cpage),
      .row_i        (crow),
      .fail_inject_i(fail_inject),
      .cache_rdy_o  (cache_rdy),
      .array_rdy_o  (array_rdy),
      .fail_last_o  (fail_last),
      .fail_prev_o  (fail_prev),
      .arr_we_o     (arr_we),
      .arr_row_o    (arr_row),
      .arr_col_o    (arr_col),
      .arr_byte_o   (arr_byte)
   );

   // status output mode: opened by 70h at any time, closed by any other accepted command
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stat_mode <= 1'b0;
      else if (ev.cmd && ev.val == OP_STATUS)
         stat_mode <= 1'b1;
      else if (ev.cmd && cache_rdy)
         stat_mode <= 1'b0;
   end

   always_comb begin
      status               = '0;
      status[SB_CACHE_RDY] = cache_rdy;
      status[SB_ARRAY_RDY] = array_rdy;
      status[SB_FAIL_PREV] = fail_prev;
      status[SB_FAIL_LAST] = fail_last;
   end

   assign rb     = cache_rdy;
   assign io_oe  = stat_mode & ~re_n;
   assign io_out = io_oe ? status : 8'h00;

   a_r7_array_rdy_needs_cache_rdy: assert property (@(posedge clk) disable iff (!rst_n)
      array_rdy |-> rb);

   a_r4_stream_only_while_array_busy: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> !array_rdy);

endmodule

// File: tb/nand_cache_prog_bench.sv
`timescale 1ns/1ps
module nand_cache_prog_bench;

   localparam int PB = 8;
   localparam int XC = 5;
   localparam int PC = 96;
   localparam int CW = 3;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, fail_inject = 1'b0;
   logic [7:0] io_in = 8'h00;
   logic [7:0] io_out, arr_byte;
   logic       io_oe, rb, arr_we;
   logic [23:0] arr_row;
   logic [CW-1:0] arr_col;

   nand_cache_prog #(.PAGE_BYTES(PB), .XFER_CYC(XC), .PROG_CYC(PC)) u_nand_cache_prog (
      .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
      .io_in(io_in), .fail_inject(fail_inject), .io_out(io_out), .io_oe(io_oe),
      .rb(rb), .arr_we(arr_we), .arr_row(arr_row), .arr_col(arr_col), .arr_byte(arr_byte)
   );

   always #2.5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0, errors = 0;
   int last_n = 0, arr_end = 0, exp_rise = 0;
   logic [7:0] dat [16];
   logic [7:0] img [PB];
   logic [34:0] expq [$];

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one bus cycle; returns at the negedge after the latching edge, last_n = that edge
   task automatic bus(input logic c, input logic a, input logic [7:0] v);
      cle = c; ale = a; io_in = v; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      last_n = cyc;
      cle = 1'b0; ale = 1'b0;
   endtask

   task automatic read_status(output logic [7:0] v);
      bus(1'b1, 1'b0, 8'h70);
      re_n = 1'b0;
      @(negedge clk);
      v = io_out;
      chk(io_oe == 1'b1, "R8 io_oe during status read", io_oe, 1);
      re_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic poll_array(output logic [7:0] v);
      v = 8'h00;
      while (!v[5]) read_status(v);
   endtask

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic start_page(input logic [23:0] row, input int scol, input int len,
                             input bit gcache, input bit fail, input bit junk);
      bus(1'b1, 1'b0, 8'h80);
      bus(1'b0, 1'b1, 8'(scol));
      bus(1'b0, 1'b1, 8'($urandom));
      bus(1'b0, 1'b1, row[7:0]);
      bus(1'b0, 1'b1, row[15:8]);
      bus(1'b0, 1'b1, row[23:16]);
      for (int i = 0; i < len; i++) bus(1'b0, 1'b0, dat[i]);
      for (int c = 0; c < PB; c++) img[c] = 8'hFF;
      for (int i = 0; i < len; i++) if (scol + i < PB) img[scol + i] = dat[i];
      for (int c = 0; c < PB; c++) expq.push_back({row, CW'(c), img[c]});
      if (junk) begin
         bus(1'b1, 1'b1, 8'h15);   // both qualifiers high: must not act as a command
         chk(rb == 1'b1, "R2 cycle with cle and ale high ignored", rb, 1);
      end
      fail_inject = fail;
      bus(1'b1, 1'b0, gcache ? 8'h15 : 8'h10);
      chk(rb == 1'b0, "R3 rb low after commit", rb, 0);
      exp_rise = max2(last_n, arr_end) + XC + (gcache ? 0 : PC);
      arr_end  = max2(last_n, arr_end) + XC + PC;
   endtask

   task automatic finish_page(input string tag);
      while (!rb) @(negedge clk);
      chk(cyc == exp_rise, tag, cyc, exp_rise);
   endtask

   // array write port checked against the expected page images
   always @(negedge clk) begin
      if (rst_n && arr_we) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R4 array byte without a committed page", {arr_row, arr_col, arr_byte}, 0);
         end else begin
            logic [34:0] e;
            e = expq.pop_front();
            chk({arr_row, arr_col, arr_byte} == e, "R1/R4 array stream byte", {arr_row, arr_col, arr_byte}, e);
         end
      end
   end

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] s;
      void'($urandom(32'd1877));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      chk(rb == 1'b1, "R11 rb after reset", rb, 1);
      chk(io_oe == 1'b0, "R11 io_oe after reset", io_oe, 0);
      chk(arr_we == 1'b0, "R11 arr_we after reset", arr_we, 0);
      read_status(s);
      chk(s == 8'h60, "R11 R7 status after reset", s, 8'h60);

      // R8 read strobe held low then pulsed, then closed by another command
      bus(1'b1, 1'b0, 8'h70);
      re_n = 1'b0;
      @(negedge clk); chk(io_out == 8'h60, "R8 first read, strobe low", io_out, 8'h60);
      @(negedge clk); chk(io_out == 8'h60, "R8 strobe held low", io_out, 8'h60);
      re_n = 1'b1; @(negedge clk); re_n = 1'b0; @(negedge clk);
      chk(io_out == 8'h60, "R8 strobe pulsed again", io_out, 8'h60);
      re_n = 1'b1;
      bus(1'b1, 1'b0, 8'hFF);
      re_n = 1'b0; @(negedge clk);
      chk(io_oe == 1'b0, "R8 other command ends status output", io_oe, 0);
      re_n = 1'b1; @(negedge clk);

      // page A: full page, 15h into an idle array
      for (int i = 0; i < 16; i++) dat[i] = 8'($urandom);
      start_page(24'h12_3456, 0, PB, 1'b1, 1'b0, 1'b0);
      finish_page("R3 first-pass release after transfer");
      read_status(s);
      chk(s == 8'h40, "R7 cache ready, array busy", s, 8'h40);

      // page B: partial load past the end, 15h while array busy
      for (int i = 0; i < 16; i++) dat[i] = 8'($urandom);
      start_page(24'hA0_B0C0, 3, 7, 1'b1, 1'b0, 1'b0);
      read_status(s);
      chk(s == 8'h00, "R8 R9 status accepted while both busy", s, 8'h00);
      bus(1'b1, 1'b0, 8'h80);
      for (int i = 0; i < 5; i++) bus(1'b0, 1'b1, 8'h01);
      bus(1'b0, 1'b0, 8'hA5);
      bus(1'b0, 1'b0, 8'h5A);
      chk(rb == 1'b0, "R9 load attempt made while busy", rb, 0);
      finish_page("R5 transfer held until array done");

      // page C: 10h with a both-qualifier cycle before it
      for (int i = 0; i < 16; i++) dat[i] = 8'($urandom);
      start_page(24'h00_0007, 1, 2, 1'b0, 1'b0, 1'b1);
      finish_page("R6 page program holds busy through array");
      read_status(s);
      chk(s == 8'h60, "R7 idle after page program", s, 8'h60);

      // pages D..G: pass/fail reporting
      start_page(24'h00_0100, 0, 4, 1'b0, 1'b1, 1'b0);
      finish_page("R6 page D release");
      fail_inject = 1'b0;
      read_status(s);
      chk(s == 8'h61, "R10 injected failure reported", s, 8'h61);
      start_page(24'h00_0101, 0, 4, 1'b0, 1'b0, 1'b0);
      finish_page("R6 page E release");
      read_status(s);
      chk(s == 8'h62, "R7 fail history shifts", s, 8'h62);
      start_page(24'h00_0102, 2, 3, 1'b1, 1'b1, 1'b0);
      finish_page("R3 page F release");
      poll_array(s);
      fail_inject = 1'b0;
      chk(s == 8'h61, "R10 failure on cache-programmed page", s, 8'h61);
      start_page(24'h00_0103, 0, 8, 1'b1, 1'b0, 1'b0);
      finish_page("R3 page G release");
      read_status(s);
      chk(s == 8'h41, "R7 bit0 gives previous page while array busy", s, 8'h41);
      poll_array(s);
      chk(s == 8'h62, "R7 bit0 gives current page once array ready", s, 8'h62);

      // random pages, mixed commits and gaps
      for (int k = 0; k < 12; k++) begin
         int  sc, ln, gap;
         bit  gc;
         for (int i = 0; i < 16; i++) dat[i] = 8'($urandom);
         sc  = int'($urandom % PB);
         ln  = int'($urandom % (PB + 3));
         gc  = (k == 11) ? 1'b0 : 1'($urandom % 2);
         gap = int'($urandom % 40);
         repeat (gap) @(negedge clk);
         start_page(24'($urandom), sc, ln, gc, 1'b0, 1'b0);
         finish_page(gc ? "R3 R5 random cache commit release" : "R6 random page commit release");
      end

      poll_array(s);
      chk(s[6:5] == 2'b11, "R7 both ready at end", s, 8'h60);
      repeat (4) @(negedge clk);
      chk(expq.size() == 0, "R4 every committed byte reached the array", expq.size(), 0);

      summary();
      $finish;
   end

endmodule